// File: doc/BRIEF.md
# Fan Drive Sequencer

This block turns a stored fan-speed code into four open-drain control lines: three active-low speed lines and an active-low shutdown line. Each line is presented as a drive-low enable, where 1 means the pin is pulled low. While running, the speed lines carry the bitwise inverse of the code. The shutdown line is pulled low only when the code is zero.

When the fan leaves the off state, the block first applies the fastest speed pattern. It keeps that pattern for a fixed start interval so that the fan spins up reliably even at a low target speed. It releases shutdown half an interval after the speed lines move. When the fan is stopped, the order is reversed: shutdown is asserted first, and the speed lines are released half an interval later.

A single interval timer handles both sequences. It runs only during them, and its enable is brought out as a flag for an oscillator power control. When fan mode is disabled, every line is released and no sequencing takes place.

Top module: `fan_drive_sequencer`

## Requirements
- R1: During and right after synchronous reset, all four drive-low enables are 0, the timer flag is 0 and the stored code is zero.
- R2: While `fan_en` is 0, all four drive-low enables and the timer flag are 0 from the next cycle on. Writes are still stored.
- R3: Only bits 2:0 of `speed_val` form the code. A write whose low three bits are zero counts as a zero write, whatever the upper bits hold.
- R4: With fan mode on and the code at zero, steady state has `shdn_pull_low`=1 and `spd_pull_low`=000, which puts the speed lines at level 111.
- R5: In steady running, `spd_pull_low` equals the code. The speed line levels are therefore its inverse, with code 001 the slowest speed and code 111 the fastest. `shdn_pull_low`=0.
- R6: A nonzero write while stopped gives `spd_pull_low`=111 from the next cycle for KICK_CYCLES cycles. `shdn_pull_low` stays 1 for the first KICK_CYCLES/2 of those cycles and then goes to 0. After that, the outputs follow R5.
- R7: A zero write while running sets `shdn_pull_low`=1 on the next cycle and leaves `spd_pull_low` unchanged. After KICK_CYCLES/2 cycles, `spd_pull_low` goes to 000.
- R8: `timer_active` is 1 exactly during the start and stop sequences, and 0 in steady off, steady running and disabled states.
- R9: A nonzero write while running applies the new code on the next cycle, with no kick.
- R10: A nonzero write during the start kick does not change the kick's length. The new code is applied when the kick ends.
- R11: A zero write during the start kick aborts it and enters the stop sequence with the speed lines held at 111.
- R12: A nonzero write during the stop sequence restarts the full start sequence.
- R13: Turning fan mode on while the stored code is nonzero starts the kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fan_en | input | 1 | Fan mode enable |
| speed_wr | input | 1 | Write strobe for the speed register |
| speed_val | input | REG_W (8) | Speed register write value; only bits 2:0 are used |
| spd_pull_low | output | CODE_W (3) | Drive-low enables for the active-low speed lines |
| shdn_pull_low | output | 1 | Drive-low enable for the active-low shutdown line |
| timer_active | output | 1 | Interval timer running (oscillator enable) |

## Verification
The bench goes after the interrupted sequences. A zero write in the middle of a kick must enter the stop sequence with the speed lines held at full speed; a design that drops straight to off, or loses the held pattern, would release the lines early. A nonzero write during the stop sequence must restart the full kick; a design that resumed the old count, or jumped straight to running, would shorten the spin-up. The bench also checks that a nonzero write during the kick leaves the interval length alone, that writes with only reserved bits set do not start the fan, and that re-enabling fan mode with a stored speed fires the kick. Any off-by-one in the half-interval or full-interval boundary shows up as a mismatch on the exact cycle where shutdown or the speed lines move.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_KICK_SHDN = 3'd1,
    ST_KICK_RUN  = 3'd2,
    ST_RUN       = 3'd3,
    ST_STOP      = 3'd4
  } fan_state_t;
endpackage

// File: rtl/fan_code_reg.sv
module fan_code_reg #(
  parameter int REG_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_W-1:0]  val,
  output logic [CODE_W-1:0] code_nxt
);
  logic [CODE_W-1:0] code_q;
  logic              unused_hi;

  // reserved upper bits never reach the stored code
  assign unused_hi = ^val[REG_W-1:CODE_W];
  assign code_nxt  = wr ? val[CODE_W-1:0] : code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_nxt;
  end
endmodule

// File: rtl/fan_interval_timer.sv
module fan_interval_timer #(
  parameter int KICK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic half_hit,
  output logic full_hit
);
  localparam int HALF  = KICK_CYCLES / 2;
  localparam int CNT_W = $clog2(KICK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_q + 1'b1;
  end

  assign half_hit = (cnt_q == CNT_W'(HALF - 1));
  assign full_hit = (cnt_q == CNT_W'(KICK_CYCLES - 1));
endmodule

// File: rtl/fan_drive_sequencer.sv
module fan_drive_sequencer #(
  parameter int REG_W       = 8,
  parameter int CODE_W      = 3,
  parameter int KICK_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fan_en,
  input  logic              speed_wr,
  input  logic [REG_W-1:0]  speed_val,
  output logic [CODE_W-1:0] spd_pull_low,
  output logic              shdn_pull_low,
  output logic              timer_active
);
  import fan_seq_pkg::*;

  fan_state_t        state_q, state_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic              code_zero;
  logic              tmr_clr, tmr_en, half_hit, full_hit;
  logic [CODE_W-1:0] spd_nxt;
  logic              shdn_nxt, act_nxt;

  fan_code_reg #(.REG_W(REG_W), .CODE_W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .wr(speed_wr), .val(speed_val), .code_nxt(code_nxt)
  );

  fan_interval_timer #(.KICK_CYCLES(KICK_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en),
    .half_hit(half_hit), .full_hit(full_hit)
  );

  assign code_zero = (code_nxt == '0);

  always_comb begin
    state_nxt = state_q;
    tmr_clr   = 1'b0;
    if (!fan_en) begin
      state_nxt = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: if (!code_zero) begin
          state_nxt = ST_KICK_SHDN; tmr_clr = 1'b1;
        end
        ST_KICK_SHDN: begin
          if (code_zero) begin
            state_nxt = ST_STOP; tmr_clr = 1'b1;
          end else if (half_hit) state_nxt = ST_KICK_RUN;
        end
        ST_KICK_RUN: begin
          if (code_zero) begin
            state_nxt = ST_STOP; tmr_clr = 1'b1;
          end else if (full_hit) state_nxt = ST_RUN;
        end
        ST_RUN: if (code_zero) begin
          state_nxt = ST_STOP; tmr_clr = 1'b1;
        end
        ST_STOP: begin
          if (!code_zero) begin
            state_nxt = ST_KICK_SHDN; tmr_clr = 1'b1;
          end else if (half_hit) state_nxt = ST_OFF;
        end
        default: state_nxt = ST_OFF;
      endcase
    end
  end

  assign tmr_en = (state_nxt == ST_KICK_SHDN) || (state_nxt == ST_KICK_RUN) ||
                  (state_nxt == ST_STOP);

  always_comb begin
    unique case (state_nxt)
      ST_KICK_SHDN, ST_KICK_RUN: spd_nxt = '1;
      ST_RUN:                    spd_nxt = code_nxt;
      ST_STOP:                   spd_nxt = spd_pull_low;
      default:                   spd_nxt = '0;
    endcase
    shdn_nxt = fan_en && ((state_nxt == ST_OFF) || (state_nxt == ST_KICK_SHDN) ||
                          (state_nxt == ST_STOP));
    act_nxt  = tmr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_OFF;
      spd_pull_low  <= '0;
      shdn_pull_low <= 1'b0;
      timer_active  <= 1'b0;
    end else begin
      state_q       <= state_nxt;
      spd_pull_low  <= spd_nxt;
      shdn_pull_low <= shdn_nxt;
      timer_active  <= act_nxt;
    end
  end
endmodule

// File: rtl/fan_seq_chk.sv
module fan_seq_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              fan_en,
  input logic [CODE_W-1:0] spd_pull_low,
  input logic              shdn_pull_low,
  input logic              timer_active
);
  // R2
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !fan_en |=> (spd_pull_low == '0) && !shdn_pull_low && !timer_active);

  // R6
  shdn_release_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(shdn_pull_low) && $past(fan_en)) |-> (&spd_pull_low));

  // R7
  shdn_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(shdn_pull_low) && $past(fan_en) && $past(fan_en, 2)) |-> $stable(spd_pull_low));

  // R8
  kick_full_speed_chk: assert property (@(posedge clk) disable iff (rst)
    (timer_active && !shdn_pull_low) |-> (&spd_pull_low));
endmodule

bind fan_drive_sequencer fan_seq_chk #(.CODE_W(CODE_W)) u_fan_seq_chk (
  .clk(clk), .rst(rst), .fan_en(fan_en), .spd_pull_low(spd_pull_low),
  .shdn_pull_low(shdn_pull_low), .timer_active(timer_active)
);

// File: tb/fan_drive_sequencer_test.sv
module fan_drive_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int K = 16;
  localparam int H = K / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fan_en = 1'b0;
  logic       speed_wr = 1'b0;
  logic [7:0] speed_val = 8'h00;
  logic [2:0] spd_pull_low;
  logic       shdn_pull_low;
  logic       timer_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural model: mode 0 off, 1 kick, 2 running, 3 stopping
  int m_mode = 0, m_t = 0, m_code = 0, m_held = 0;
  int e_spd = 0, e_shdn = 0, e_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_drive_sequencer #(.REG_W(8), .CODE_W(3), .KICK_CYCLES(K)) uut (
    .clk(clk), .rst(rst), .fan_en(fan_en), .speed_wr(speed_wr), .speed_val(speed_val),
    .spd_pull_low(spd_pull_low), .shdn_pull_low(shdn_pull_low), .timer_active(timer_active)
  );

  always @(posedge clk) begin
    int nc;
    cyc++;
    if (rst) begin
      m_mode = 0; m_t = 0; m_code = 0; m_held = 0;
    end else begin
      nc = speed_wr ? int'(speed_val & 8'h07) : m_code;
      if (!fan_en) m_mode = 0;
      else if (m_mode == 0) begin
        if (nc != 0) begin m_mode = 1; m_t = 0; end
      end else if (m_mode == 1) begin
        if (nc == 0) begin m_held = 7; m_mode = 3; m_t = 0; end
        else begin m_t++; if (m_t == K) m_mode = 2; end
      end else if (m_mode == 2) begin
        if (nc == 0) begin m_held = m_code; m_mode = 3; m_t = 0; end
      end else begin
        if (nc != 0) begin m_mode = 1; m_t = 0; end
        else begin m_t++; if (m_t == H) m_mode = 0; end
      end
      m_code = nc;
    end
    if (rst || !fan_en) begin e_spd = 0; e_shdn = 0; e_act = 0; end
    else case (m_mode)
      0: begin e_spd = 0; e_shdn = 1; e_act = 0; end
      1: begin e_spd = 7; e_shdn = (m_t < H) ? 1 : 0; e_act = 1; end
      2: begin e_spd = m_code; e_shdn = 0; e_act = 0; end
      default: begin e_spd = m_held; e_shdn = 1; e_act = 1; end
    endcase
  end

  always @(negedge clk) begin
    if (cyc > 0) begin
      checks++;
      if (int'(spd_pull_low) != e_spd || int'(shdn_pull_low) != e_shdn ||
          int'(timer_active) != e_act) begin
        errors++;
        $display("FAIL %s cycle %0d: spd=%0d shdn=%0d act=%0d expected spd=%0d shdn=%0d act=%0d",
                 cur_req, cyc, spd_pull_low, shdn_pull_low, timer_active, e_spd, e_shdn, e_act);
      end
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    speed_wr = 1'b1; speed_val = v;
    @(negedge clk);
    speed_wr = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    cur_req = "R2";
    wr(8'h05);
    wait_cyc(5);
    cur_req = "R13";
    fan_en = 1'b1;
    wait_cyc(K + 4);
    cur_req = "R9";
    wr(8'h03);
    wait_cyc(3);
    cur_req = "R7";
    wr(8'h00);
    wait_cyc(H + 4);
    cur_req = "R3";
    wr(8'h08);
    wait_cyc(3);
    cur_req = "R4";
    wait_cyc(3);
    cur_req = "R6";
    wr(8'h01);
    wait_cyc(K + 4);
    cur_req = "R5";
    for (int c = 2; c < 8; c++) begin
      wr(8'hF0 | 8'(c));
      wait_cyc(2);
    end
    cur_req = "R12";
    wr(8'h00);
    wait_cyc(3);
    wr(8'h06);
    wait_cyc(K + 4);
    cur_req = "R10";
    wr(8'h00);
    wait_cyc(H + 2);
    wr(8'h02);
    wait_cyc(4);
    wr(8'h07);
    wait_cyc(K + 2);
    cur_req = "R11";
    wr(8'h00);
    wait_cyc(H + 2);
    wr(8'h04);
    wait_cyc(H + 2);
    wr(8'h00);
    wait_cyc(H + 4);
    cur_req = "R8";
    wr(8'h03);
    wait_cyc(K + 4);
    cur_req = "R2";
    fan_en = 1'b0;
    wait_cyc(4);
    cur_req = "R13";
    fan_en = 1'b1;
    wait_cyc(K + 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule